// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Unit

This unit sits between an internal 32-bit bus master and external memories and peripherals. It compares each access address against eight programmable regions. It then drives one active-low select strobe for the winning region and reports that region's port width and burst capability. After the region's programmed number of wait cycles it returns a single-cycle transfer acknowledge. An address that no enabled region claims produces a one-cycle bus error. The last region can instead be handed to an external SDRAM controller, which is signalled by a one-cycle request pulse.

Software programs each region through a small write port. The write carries a region index, a field selector (base, mask or options) and a 32-bit data word. Coming out of reset, only region 0 is live. It acts as a catch-all boot region whose port width is taken from a 2-bit strap input during reset.

Top module: `csel_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, all strobes are high and `ack`, `berr` and `sdram_req` are low. After reset only region 0 is enabled, with base 0, mask all ones and 31 wait cycles, so it claims every address.
- R2: Region 0's reset width is sampled from `strap_width` while reset is held. `cs_width` reports widths as 00 = 32-bit, 01 = 8-bit and 10 = 16-bit. A stored code of 11 is reported as 00.
- R3: A region matches when `(acc_addr ^ base) & ~mask` is zero, so a mask bit of 1 marks a don't-care address bit.
- R4: When several enabled regions match, the lowest-numbered region is selected.
- R5: Suppose an idle unit samples `acc_valid` high at edge T and the region has W wait cycles. The strobe for that region is then low from T+1. `ack` is high for the single cycle T+1+W, and the strobe is high again in the following cycle. `cs_width` and `cs_burst` hold the region's options while the strobe is low and read 00 and 0 otherwise.
- R6: An access that matches no enabled region drives `berr` high for exactly the cycle after sampling, and no strobe falls.
- R7: If region 7 wins while its SDRAM bit is set, `sdram_req` is high for the cycle after sampling, and no strobe, `ack` or `berr` is produced. The SDRAM bit written to any other region is discarded.
- R8: A config write with `cfg_field` 00 sets base, 01 sets mask and 10 sets options. Field 11 changes nothing. The options layout is bit 0 enable, bits 2:1 width code, bit 3 burst, bits 8:4 wait count and bit 9 SDRAM mode. A write takes effect for accesses sampled after its edge, and the access already in progress keeps its latched options.
- R9: A disabled region never matches, and at most one strobe is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_width | input | 2 | Boot region width code, sampled during reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Region index for the write |
| cfg_field | input | 2 | Field select: base, mask, options, none |
| cfg_data | input | 32 | Write data |
| acc_valid | input | 1 | Access request, sampled when idle |
| acc_addr | input | 32 | Access address |
| cs_n | output | 8 | Active-low region strobes |
| cs_width | output | 2 | Port width code of the active region |
| cs_burst | output | 1 | Burst capability of the active region |
| ack | output | 1 | Transfer acknowledge, one cycle |
| berr | output | 1 | Unclaimed address, one cycle |
| sdram_req | output | 1 | Region 7 claimed in SDRAM mode, one cycle |

## Verification
The assertions assume that a master lowers `acc_valid` in the cycle that follows a `berr` or `sdram_req` pulse. Without that, a second unclaimed access could start at once, and the error pulse would repeat back to back. The stimulus raises `acc_valid` for exactly one sampling edge per access and then waits for the unit to finish before starting the next one. With that stimulus, each pulse stands alone. Configuration writes may land during an access, and the bench places one there on purpose.

// File: rtl/csel_pkg.sv
package csel_pkg;
    localparam int ADDR_W = 32;
    localparam int WAIT_W = 5;

    typedef enum logic [1:0] {
        PW_32  = 2'b00,
        PW_8   = 2'b01,
        PW_16  = 2'b10,
        PW_RSV = 2'b11
    } pw_e;

    typedef enum logic [1:0] {
        FLD_BASE = 2'b00,
        FLD_MASK = 2'b01,
        FLD_OPT  = 2'b10,
        FLD_NONE = 2'b11
    } fld_e;

    // bit 9 sdram, 8:4 wait, 3 burst, 2:1 width, 0 enable
    typedef struct packed {
        logic              sdram;
        logic [WAIT_W-1:0] wait_n;
        logic              burst;
        pw_e               pw;
        logic              en;
    } opt_t;

    localparam int OPT_W = $bits(opt_t);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
        opt_t              opt;
    } region_t;

    function automatic pw_e pw_norm(pw_e p);
        return (p == PW_RSV) ? PW_32 : p;
    endfunction
endpackage

// File: rtl/csel_regfile.sv
module csel_regfile import csel_pkg::*; #(
    parameter int NUM_CS = 8,
    localparam int IDX_W = $clog2(NUM_CS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   strap_width,
    input  logic                         cfg_we,
    input  logic [IDX_W-1:0]             cfg_idx,
    input  logic [1:0]                   cfg_field,
    input  logic [ADDR_W-1:0]            cfg_data,
    output region_t [NUM_CS-1:0]         regs_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CS - 1);

    region_t [NUM_CS-1:0] regs_d, regs_q, regs_rst;

    always_comb begin
        regs_d = regs_q;
        if (cfg_we) begin
            case (fld_e'(cfg_field))
                FLD_BASE: regs_d[cfg_idx].base = cfg_data;
                FLD_MASK: regs_d[cfg_idx].mask = cfg_data;
                FLD_OPT: begin
                    regs_d[cfg_idx].opt = opt_t'(cfg_data[OPT_W-1:0]);
                    if (cfg_idx != LAST) regs_d[cfg_idx].opt.sdram = 1'b0;
                end
                default: ;
            endcase
        end
        for (int i = 0; i < NUM_CS; i++) regs_rst[i] = '0;
        regs_rst[0].mask       = '1;
        regs_rst[0].opt.en     = 1'b1;
        regs_rst[0].opt.pw     = pw_e'(strap_width);
        regs_rst[0].opt.wait_n = '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= regs_rst;
        else        regs_q <= regs_d;
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/csel_match.sv
module csel_match import csel_pkg::*; #(
    parameter int NUM_CS = 8,
    localparam int IDX_W = $clog2(NUM_CS)
) (
    input  region_t [NUM_CS-1:0] regs,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 hit,
    output logic [IDX_W-1:0]     win
);
    logic [NUM_CS-1:0] hits;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
        assign hits[g] = regs[g].opt.en &&
                         (((addr ^ regs[g].base) & ~regs[g].mask) == '0);
    end

    always_comb begin
        hit = |hits;
        win = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (hits[i]) win = IDX_W'(i);
        end
    end
endmodule

// File: rtl/csel_seq.sv
module csel_seq import csel_pkg::*; #(
    parameter int NUM_CS = 8,
    localparam int IDX_W = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              hit,
    input  logic [IDX_W-1:0]  win,
    input  opt_t              win_opt,
    output logic [NUM_CS-1:0] cs_n,
    output logic [1:0]        cs_width,
    output logic              cs_burst,
    output logic              ack,
    output logic              berr,
    output logic              sdram_req
);
    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [WAIT_W-1:0] cnt;
        pw_e               pw;
        logic              burst;
        logic              berr;
        logic              sdreq;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.berr  = 1'b0;
        s_d.sdreq = 1'b0;
        if (s_q.busy) begin
            if (s_q.cnt == '0) s_d.busy = 1'b0;
            else               s_d.cnt  = s_q.cnt - 1'b1;
        end else if (acc_valid) begin
            if (!hit) begin
                s_d.berr = 1'b1;
            end else if (win_opt.sdram) begin
                s_d.sdreq = 1'b1;
            end else begin
                s_d.busy  = 1'b1;
                s_d.idx   = win;
                s_d.cnt   = win_opt.wait_n;
                s_d.pw    = pw_norm(win_opt.pw);
                s_d.burst = win_opt.burst;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{busy: 1'b0, idx: '0, cnt: '0, pw: PW_32,
                             burst: 1'b0, berr: 1'b0, sdreq: 1'b0};
        else        s_q <= s_d;
    end

    always_comb begin
        cs_n = '1;
        if (s_q.busy) cs_n[s_q.idx] = 1'b0;
    end

    assign ack       = s_q.busy && (s_q.cnt == '0);
    assign cs_width  = s_q.busy ? s_q.pw : PW_32;
    assign cs_burst  = s_q.busy && s_q.burst;
    assign berr      = s_q.berr;
    assign sdram_req = s_q.sdreq;
endmodule

// File: rtl/csel_unit.sv
module csel_unit import csel_pkg::*; #(
    parameter int NUM_CS = 8,
    localparam int IDX_W = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_width,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_field,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [NUM_CS-1:0] cs_n,
    output logic [1:0]        cs_width,
    output logic              cs_burst,
    output logic              ack,
    output logic              berr,
    output logic              sdram_req
);
    region_t [NUM_CS-1:0] regs;
    logic                 hit;
    logic [IDX_W-1:0]     win;
    opt_t                 win_opt;

    csel_regfile #(.NUM_CS(NUM_CS)) u_regs (
        .clk(clk), .rst_n(rst_n), .strap_width(strap_width),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_field(cfg_field),
        .cfg_data(cfg_data), .regs_o(regs)
    );

    csel_match #(.NUM_CS(NUM_CS)) u_match (
        .regs(regs), .addr(acc_addr), .hit(hit), .win(win)
    );

    assign win_opt = regs[win].opt;

    csel_seq #(.NUM_CS(NUM_CS)) u_seq (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .hit(hit),
        .win(win), .win_opt(win_opt), .cs_n(cs_n), .cs_width(cs_width),
        .cs_burst(cs_burst), .ack(ack), .berr(berr), .sdram_req(sdram_req)
    );
endmodule

// File: rtl/csel_unit_chk.sv
module csel_unit_chk #(
    parameter int NUM_CS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [NUM_CS-1:0] cs_n,
    input logic [1:0]        cs_width,
    input logic              cs_burst,
    input logic              ack,
    input logic              berr,
    input logic              sdram_req
);
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R9
    AST_ACK_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (cs_n != '1)); // R5
    AST_RELEASE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (cs_n == '1)); // R5
    AST_IDLE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n == '1) |-> (cs_width == 2'b00 && !cs_burst)); // R5
    AST_BERR_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        berr |-> (cs_n == '1 && !ack && !sdram_req)); // R6
    AST_BERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        berr |=> !berr); // R6
    AST_SDRAM_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sdram_req |-> (cs_n == '1 && !ack && !berr)); // R7
    AST_WIDTH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_width != 2'b11); // R2
endmodule

bind csel_unit csel_unit_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .cs_n(cs_n),
    .cs_width(cs_width), .cs_burst(cs_burst), .ack(ack), .berr(berr),
    .sdram_req(sdram_req)
);

// File: tb/csel_unit_tb.sv
module csel_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  strap_width = 2'b00;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [1:0]  cfg_field = '0;
    logic [31:0] cfg_data = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [7:0]  cs_n;
    logic [1:0]  cs_width;
    logic        cs_burst, ack, berr, sdram_req;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit running = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    csel_unit u_dut (.*);

    // reference model
    logic [31:0] m_base [NCS];
    logic [31:0] m_mask [NCS];
    bit          m_en [NCS];
    int          m_pw [NCS];
    bit          m_bu [NCS];
    int          m_wt [NCS];
    bit          m_sd [NCS];
    bit m_busy, m_berr, m_sdq, m_lbu;
    int m_idx, m_cnt, m_lpw;

    function automatic int norm_pw(int c);
        return (c == 3) ? 0 : c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCS; i++) begin
                m_base[i] = 0; m_mask[i] = 0; m_en[i] = 0; m_pw[i] = 0;
                m_bu[i] = 0; m_wt[i] = 0; m_sd[i] = 0;
            end
            m_mask[0] = 32'hFFFF_FFFF; m_en[0] = 1; m_wt[0] = 31;
            m_pw[0] = int'(strap_width);
            m_busy = 0; m_berr = 0; m_sdq = 0; m_idx = 0; m_cnt = 0;
            m_lpw = 0; m_lbu = 0;
        end else begin
            m_berr = 0; m_sdq = 0;
            if (m_busy) begin
                if (m_cnt == 0) m_busy = 0; else m_cnt--;
            end else if (acc_valid) begin
                int w;
                w = -1;
                for (int i = 0; i < NCS; i++)
                    if (w < 0 && m_en[i] && ((acc_addr ^ m_base[i]) & ~m_mask[i]) == 0) w = i;
                if (w < 0) m_berr = 1;
                else if (w == NCS-1 && m_sd[w]) m_sdq = 1;
                else begin
                    m_busy = 1; m_idx = w; m_cnt = m_wt[w];
                    m_lpw = norm_pw(m_pw[w]); m_lbu = m_bu[w];
                end
            end
            if (cfg_we) begin
                case (cfg_field)
                    2'd0: m_base[cfg_idx] = cfg_data;
                    2'd1: m_mask[cfg_idx] = cfg_data;
                    2'd2: begin
                        m_en[cfg_idx] = cfg_data[0];
                        m_pw[cfg_idx] = int'(cfg_data[2:1]);
                        m_bu[cfg_idx] = cfg_data[3];
                        m_wt[cfg_idx] = int'(cfg_data[8:4]);
                        m_sd[cfg_idx] = (cfg_idx == 3'(NCS-1)) ? cfg_data[9] : 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [14:0] model_out();
        logic [7:0] c;
        c = 8'hFF;
        if (m_busy) c[m_idx] = 1'b0;
        return {c, m_busy ? 2'(m_lpw) : 2'b00, m_busy & m_lbu,
                m_busy && m_cnt == 0, m_berr, m_sdq};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (running) check(cur_req, 32'({cs_n, cs_width, cs_burst, ack, berr, sdram_req}),
                           32'(model_out()));
        if (cycles > 100000) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    function automatic logic [31:0] mkopt(bit en, int pw, bit bu, int wt, bit sd);
        return {22'd0, sd, 5'(wt), bu, 2'(pw), en};
    endfunction

    task automatic do_reset(input logic [1:0] strap);
        @(negedge clk);
        rst_n = 0; strap_width = strap;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr(input int idx, input int fld, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 3'(idx); cfg_field = 2'(fld); cfg_data = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic access(input logic [31:0] a, input int exp_lat, input string req);
        int n;
        @(negedge clk);
        acc_valid = 1; acc_addr = a;
        @(negedge clk);
        acc_valid = 0;
        n = 1;
        while (!ack && !berr && !sdram_req && n < 40) begin
            @(negedge clk); n++;
        end
        check(req, 32'(n), 32'(exp_lat));
        @(negedge clk);
        check(req, 32'(cs_n), 32'hFF);
    endtask

    initial begin
        running = 1;
        cur_req = "R1";
        do_reset(2'b01);
        check("R1", 32'({cs_n, ack, berr, sdram_req}), 32'({8'hFF, 3'b000}));
        cur_req = "R2";
        access(32'h1234_5678, 32, "R1");
        do_reset(2'b11);
        access(32'hFFFF_FFFC, 32, "R2");
        do_reset(2'b10);
        @(negedge clk); acc_valid = 1; acc_addr = 32'h0000_0040;
        @(negedge clk); acc_valid = 0;
        check("R2", 32'(cs_width), 32'h2);
        repeat (33) @(negedge clk);

        cur_req = "R3";
        wr(0, 1, 32'h000F_FFFF);
        wr(0, 2, mkopt(1, 0, 0, 0, 0));
        wr(1, 0, 32'h1000_0000); wr(1, 1, 32'h0000_FFFF);
        wr(1, 2, mkopt(1, 2, 1, 3, 1));
        wr(2, 0, 32'h1000_0000); wr(2, 1, 32'h00FF_FFFF);
        wr(2, 2, mkopt(1, 1, 0, 5, 0));
        access(32'h0004_0000, 1, "R3");
        access(32'h1001_0000, 6, "R3");
        cur_req = "R4";
        access(32'h1000_1234, 4, "R4");
        cur_req = "R6";
        access(32'h2000_0000, 1, "R6");
        check("R6", 32'(berr), 0);
        cur_req = "R9";
        wr(3, 0, 32'h3000_0000); wr(3, 1, 32'h0000_00FF);
        wr(3, 2, mkopt(0, 0, 0, 2, 0));
        access(32'h3000_0010, 1, "R9");
        wr(3, 2, mkopt(1, 3, 0, 2, 0));
        access(32'h3000_0010, 3, "R9");

        cur_req = "R7";
        wr(7, 0, 32'h4000_0000); wr(7, 1, 32'h0FFF_FFFF);
        wr(7, 2, mkopt(1, 0, 1, 1, 1));
        access(32'h4123_0000, 1, "R7");
        wr(7, 2, mkopt(1, 0, 1, 1, 0));
        access(32'h4123_0000, 2, "R7");
        wr(5, 0, 32'h5000_0000); wr(5, 1, 32'h0000_0FFF);
        wr(5, 2, mkopt(1, 2, 0, 0, 1));
        access(32'h5000_0123, 1, "R7");

        cur_req = "R8";
        wr(1, 3, 32'h0000_0000);
        access(32'h1000_0004, 4, "R8");
        @(negedge clk); acc_valid = 1; acc_addr = 32'h1020_0000;
        @(negedge clk); acc_valid = 0;
        cfg_we = 1; cfg_idx = 3'd2; cfg_field = 2'd2; cfg_data = mkopt(1, 0, 0, 1, 0);
        begin
            int n;
            @(negedge clk); cfg_we = 0; n = 2;
            while (!ack && n < 40) begin @(negedge clk); n++; end
            check("R8", 32'(n), 32'd6);
        end
        @(negedge clk);
        access(32'h1020_0000, 2, "R8");

        running = 0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule